// File: doc/BRIEF.md
# Serial Flash Read DMA Engine

This engine moves a block of serial flash contents into system memory without processor help. Software loads a flash source address, a destination base and an exclusive destination limit, picks a lane arrangement and address width, then writes the run bit. The engine drives one continuous read frame on the flash pins: command byte, address, optional dummy clocks, then data. It gathers incoming bytes into 128-bit words and presents each full word on a valid/ready write port. When the final word is accepted, the run bit drops and a completion flag is raised.

The register port is a plain word-indexed write strobe with a read bus that is valid one cycle after the index is presented. The register map, by index, is: 0 control (bit 0 run), 1 flash source, 2 destination base, 3 destination limit, 4 lane setup, 5 options (bit 0 fast read), 6 opcode used with two data lanes, 7 opcode used with four data lanes, 8 status (bit 7 completion, write 1 to clear).

Top module: `fdma_reader`

## Requirements
- R1: After reset the control and status registers read 0, `irq` is low, `flash_cs_n` is high, `flash_sclk` is low and `mem_valid` is low.
- R2: Writing 1 to control bit 0 makes it read 1 until the last 128-bit word has been accepted; in that same cycle it reads 0 again, status bit 7 and `irq` go high, and writing a 1 to status bit 7 clears both.
- R3: The command byte is chosen as: lane setup bit 2 set gives the index-7 opcode; otherwise bit 0 set gives the index-6 opcode; otherwise options bit 0 set gives 0x0B; otherwise 0x03. It is sent MSB first on `flash_io_out[0]`.
- R4: With lane setup bit 4 clear the address is the low 24 bits of the source, else all 32 bits, MSB first. It uses four lanes when bits 2 and 3 are both set, two lanes when bit 2 is clear and bits 0 and 1 are set, else one lane; with several lanes the highest-numbered pin carries the most significant bit.
- R5: Exactly 8 dummy clocks follow the address for every frame except a one-lane read with options bit 0 clear, which has none.
- R6: Data comes in MSB first on `flash_io_in[1]` (one lane), `flash_io_in[1:0]` (bit 0 of lane setup, two lanes) or `flash_io_in[3:0]` (bit 2, four lanes), sampled at the rising serial clock edge.
- R7: Bytes are packed little-endian (first byte in bits 7:0); the word count is (limit - base)/16, the first word goes to the base address and each next one 16 higher.
- R8: While a word waits with `mem_ready` low, the serial clock is held low and no incoming byte is lost.
- R9: While the run bit is set, writes to indices 0 to 7 have no effect.
- R10: Starting with limit equal to base issues no frame, leaves the run bit at 0 and sets status bit 7.
- R11: `flash_cs_n` stays low over the whole frame, rises with the last data clock, and the serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after index |
| irq | output | 1 | Completion flag |
| flash_sclk | output | 1 | Serial clock, idles low |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_io_out | output | 4 | Serial lanes, outbound |
| flash_io_oe | output | 4 | Lane drive enables |
| flash_io_in | input | 4 | Serial lanes, inbound |
| mem_valid | output | 1 | Write word valid |
| mem_ready | input | 1 | Write word accepted |
| mem_addr | output | 32 | Write word byte address |
| mem_data | output | 128 | Write word, little-endian bytes |

## Verification
The assertions assume software keeps base, limit and source on 16-byte boundaries with limit not below base, and that `mem_ready` is the only inbound flow control. They also rely on the flash returning a data bit before each rising serial clock edge. The stimulus only programs aligned addresses and whole-word lengths, drives `mem_ready` in an irregular pattern plus one long forced stall, and models the flash so that it shifts its output after each falling edge.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  // lane code: 0 = one lane, 1 = two lanes, 2 = four lanes
  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic [1:0] alane;
    logic [1:0] dlane;
    logic       wide_addr;
    logic       dummy;
  } frame_cfg_t;
endpackage

// File: rtl/fdma_frame_seq.sv
module fdma_frame_seq
  import fdma_pkg::*;
#(
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  frame_cfg_t    cfg,
  input  logic [31:0]   src,
  input  logic [LW-1:0] nbytes,
  input  logic          hold,
  input  logic [3:0]    io_in,
  output logic          sclk,
  output logic          cs_n,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe,
  output logic          byte_vld,
  output logic [7:0]    byte_dat
);
  localparam int CKW = 6;

  phase_e         st;
  frame_cfg_t     c;
  logic [31:0]    tx;
  logic [31:0]    srcq;
  logic [CKW-1:0] clk_left;
  logic [7:0]     rx, rx_nx;
  logic [LW-1:0]  bytes_left;
  logic [1:0]     lsh;

  always_comb begin
    case (st)
      PH_ADDR: lsh = c.alane;
      PH_DATA: lsh = c.dlane;
      default: lsh = 2'd0;
    endcase
  end

  always_comb begin
    case (lsh)
      2'd0:    io_out = {3'b000, tx[31]};
      2'd1:    io_out = {2'b00, tx[31:30]};
      default: io_out = tx[31:28];
    endcase
    case (st)
      PH_CMD:  io_oe = 4'b0001;
      PH_ADDR: io_oe = (c.alane == 2'd0) ? 4'b0001 : (c.alane == 2'd1) ? 4'b0011 : 4'b1111;
      default: io_oe = 4'b0000;
    endcase
    case (c.dlane)
      2'd0:    rx_nx = {rx[6:0], io_in[1]};
      2'd1:    rx_nx = {rx[5:0], io_in[1:0]};
      default: rx_nx = {rx[3:0], io_in[3:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      c          <= '0;
      tx         <= '0;
      srcq       <= '0;
      clk_left   <= '0;
      rx         <= '0;
      bytes_left <= '0;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      byte_vld   <= 1'b0;
      byte_dat   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (st == PH_IDLE) begin
        if (go) begin
          c          <= cfg;
          srcq       <= src;
          tx         <= {cfg.opcode, 24'h0};
          clk_left   <= CKW'(8);
          bytes_left <= nbytes;
          cs_n       <= 1'b0;
          st         <= PH_CMD;
        end
      end else if (!sclk) begin
        if (!hold) sclk <= 1'b1;
      end else begin
        sclk     <= 1'b0;
        tx       <= tx << (6'd1 << lsh);
        clk_left <= clk_left - 1'b1;
        if (st == PH_DATA) rx <= rx_nx;
        if (clk_left == CKW'(1)) begin
          case (st)
            PH_CMD: begin
              st       <= PH_ADDR;
              tx       <= c.wide_addr ? srcq : {srcq[23:0], 8'h00};
              clk_left <= (c.wide_addr ? CKW'(32) : CKW'(24)) >> c.alane;
            end
            PH_ADDR: begin
              st       <= c.dummy ? PH_DUMMY : PH_DATA;
              clk_left <= c.dummy ? CKW'(8) : (CKW'(8) >> c.dlane);
            end
            PH_DUMMY: begin
              st       <= PH_DATA;
              clk_left <= CKW'(8) >> c.dlane;
            end
            default: begin
              byte_vld   <= 1'b1;
              byte_dat   <= rx_nx;
              bytes_left <= bytes_left - 1'b1;
              clk_left   <= CKW'(8) >> c.dlane;
              if (bytes_left == LW'(1)) begin
                st   <= PH_IDLE;
                cs_n <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hold && !sclk && !cs_n) |=> !sclk); // R8
endmodule

// File: rtl/fdma_beat_pack.sv
module fdma_beat_pack #(
  parameter int DW = 128,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          byte_vld,
  input  logic [7:0]    byte_dat,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          beat_take
);
  localparam int BEATB = DW / 8;
  localparam int IDXW  = $clog2(BEATB);

  logic [DW-1:0]   acc, acc_nx;
  logic [IDXW-1:0] idx;
  logic [AW-1:0]   ptr;

  assign beat_take = mem_valid && mem_ready;

  always_comb begin
    acc_nx = acc;
    acc_nx[idx*8 +: 8] = byte_dat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      idx       <= '0;
      ptr       <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      if (beat_take) mem_valid <= 1'b0;
      if (start) begin
        idx <= '0;
        ptr <= base;
      end else if (byte_vld) begin
        acc <= acc_nx;
        idx <= idx + 1'b1;
        if (idx == IDXW'(BEATB - 1)) begin
          mem_data  <= acc_nx;
          mem_addr  <= ptr;
          mem_valid <= 1'b1;
          ptr       <= ptr + AW'(BEATB);
        end
      end
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && idx == IDXW'(BEATB - 1)) |-> (!mem_valid || mem_ready)); // R8
  AST_VALID_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data) && $stable(mem_addr))); // R8
endmodule

// File: rtl/fdma_reader.sv
module fdma_reader
  import fdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          flash_sclk,
  output logic          flash_cs_n,
  output logic [3:0]    flash_io_out,
  output logic [3:0]    flash_io_oe,
  input  logic [3:0]    flash_io_in,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  localparam int OFS = $clog2(DW / 8);

  logic [31:0]     src_q;
  logic [AW-1:0]   dst_lo, dst_hi, xfer_len;
  logic [4:0]      bus_q;
  logic            fast_q, busy, done_q, go_q, beat_take;
  logic [7:0]      opc_dual, opc_quad;
  logic [AW-OFS-1:0] beats_left;
  logic            use_quad, use_dual, byte_vld;
  logic [7:0]      byte_dat;
  frame_cfg_t      fcfg;

  assign xfer_len = dst_hi - dst_lo;
  assign use_quad = bus_q[2];
  assign use_dual = bus_q[0] && !use_quad;
  assign irq      = done_q;

  always_comb begin
    fcfg.opcode    = use_quad ? opc_quad : use_dual ? opc_dual : fast_q ? 8'h0B : 8'h03;
    fcfg.dlane     = use_quad ? 2'd2 : use_dual ? 2'd1 : 2'd0;
    fcfg.alane     = (use_quad && bus_q[3]) ? 2'd2 : (use_dual && bus_q[1]) ? 2'd1 : 2'd0;
    fcfg.wide_addr = bus_q[4];
    fcfg.dummy     = use_quad || use_dual || fast_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0; dst_lo <= '0; dst_hi <= '0; bus_q <= '0; fast_q <= 1'b0;
      opc_dual <= '0; opc_quad <= '0; busy <= 1'b0; done_q <= 1'b0;
      go_q <= 1'b0; beats_left <= '0; reg_rdata <= '0;
    end else begin
      go_q <= 1'b0;
      if (reg_we && reg_addr == 4'd8 && reg_wdata[7]) done_q <= 1'b0;
      if (reg_we && !busy) begin
        case (reg_addr)
          4'd0: if (reg_wdata[0]) begin
            if (xfer_len == '0) done_q <= 1'b1;
            else begin
              busy       <= 1'b1;
              go_q       <= 1'b1;
              beats_left <= xfer_len[AW-1:OFS];
            end
          end
          4'd1: src_q    <= reg_wdata;
          4'd2: dst_lo   <= AW'(reg_wdata);
          4'd3: dst_hi   <= AW'(reg_wdata);
          4'd4: bus_q    <= reg_wdata[4:0];
          4'd5: fast_q   <= reg_wdata[0];
          4'd6: opc_dual <= reg_wdata[7:0];
          4'd7: opc_quad <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (busy && beat_take) begin
        beats_left <= beats_left - 1'b1;
        if (beats_left == (AW-OFS)'(1)) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
      case (reg_addr)
        4'd0: reg_rdata <= {31'h0, busy};
        4'd1: reg_rdata <= src_q;
        4'd2: reg_rdata <= 32'(dst_lo);
        4'd3: reg_rdata <= 32'(dst_hi);
        4'd4: reg_rdata <= {27'h0, bus_q};
        4'd5: reg_rdata <= {31'h0, fast_q};
        4'd6: reg_rdata <= {24'h0, opc_dual};
        4'd7: reg_rdata <= {24'h0, opc_quad};
        4'd8: reg_rdata <= {24'h0, done_q, 7'h0};
        default: reg_rdata <= '0;
      endcase
    end
  end

  fdma_frame_seq #(.LW(AW)) u_seq (
    .clk(clk), .rst(rst), .go(go_q), .cfg(fcfg), .src(src_q), .nbytes(xfer_len),
    .hold(mem_valid && !mem_ready), .io_in(flash_io_in), .sclk(flash_sclk),
    .cs_n(flash_cs_n), .io_out(flash_io_out), .io_oe(flash_io_oe),
    .byte_vld(byte_vld), .byte_dat(byte_dat)
  );

  fdma_beat_pack #(.DW(DW), .AW(AW)) u_pack (
    .clk(clk), .rst(rst), .start(go_q), .base(dst_lo), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .mem_ready(mem_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .beat_take(beat_take)
  );

  AST_START_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !beat_take) |=> busy); // R2
  AST_DONE_AFTER: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_q); // R2
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> flash_cs_n); // R11
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(bus_q) && $stable(src_q) && $stable(dst_lo))); // R9
endmodule

// File: tb/fdma_reader_test.sv
module fdma_reader_test;
  typedef struct packed {
    logic [4:0]  bus;
    logic        fast;
    logic [31:0] src;
    logic [31:0] dst;
    logic [7:0]  nb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{5'h00, 1'b0, 32'hFF001230, 32'h10000000, 8'd2},
    '{5'h00, 1'b1, 32'h00ABC100, 32'h10000100, 8'd1},
    '{5'h10, 1'b0, 32'h12345670, 32'h20000000, 8'd2},
    '{5'h01, 1'b0, 32'h00004440, 32'h20001000, 8'd2},
    '{5'h03, 1'b1, 32'h00010000, 32'h30000000, 8'd1},
    '{5'h14, 1'b0, 32'hFEDC0010, 32'h30000200, 8'd3},
    '{5'h0C, 1'b0, 32'h00777700, 32'h40000000, 8'd2},
    '{5'h05, 1'b1, 32'h00000020, 32'h40000400, 8'd1}
  };

  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, flash_sclk, flash_cs_n, mem_valid, mem_ready = 0;
  logic [3:0] flash_io_out, flash_io_oe, flash_io_in = 0;
  logic [31:0] mem_addr;
  logic [127:0] mem_data;

  always #2.5 clk = ~clk;

  fdma_reader uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .flash_sclk(flash_sclk), .flash_cs_n(flash_cs_n),
    .flash_io_out(flash_io_out), .flash_io_oe(flash_io_oe), .flash_io_in(flash_io_in),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
  endfunction

  // flash model configuration (set by bench from the requirements)
  int fm_al = 1, fm_dl = 1, fm_dum = 0, fm_wide = 0;
  int fm_cnt = 0, cs_falls = 0;
  logic [7:0] fm_op = 0;
  logic [31:0] fm_addr = 0;

  function automatic int hdr_len();
    return 8 + (fm_wide ? 32 : 24) / fm_al + fm_dum;
  endfunction

  always @(negedge flash_cs_n) begin
    fm_cnt = 0; fm_op = 0; fm_addr = 0; cs_falls++;
  end

  always @(posedge flash_sclk) if (!flash_cs_n) begin
    if (fm_cnt < 8) fm_op = {fm_op[6:0], flash_io_out[0]};
    else if (fm_cnt < 8 + (fm_wide ? 32 : 24) / fm_al) begin
      if (fm_al == 1) fm_addr = {fm_addr[30:0], flash_io_out[0]};
      else if (fm_al == 2) fm_addr = {fm_addr[29:0], flash_io_out[1:0]};
      else fm_addr = {fm_addr[27:0], flash_io_out[3:0]};
    end
    fm_cnt++;
  end

  always @(negedge flash_sclk) if (!flash_cs_n && fm_cnt >= hdr_len()) begin
    int k, per;
    logic [7:0] b;
    k   = fm_cnt - hdr_len();
    per = 8 / fm_dl;
    b   = pat(fm_addr + 32'(k / per)) << ((k % per) * fm_dl);
    if (fm_dl == 1) flash_io_in <= {2'b00, b[7], 1'b0};
    else if (fm_dl == 2) flash_io_in <= {2'b00, b[7:6]};
    else flash_io_in <= b[7:4];
  end

  // memory sink
  int rc = 0, sink_k = 0, sink_err = 0;
  bit stall_force = 0;
  logic [31:0] exp_src = 0, exp_dst = 0;

  always @(negedge clk) begin
    rc++;
    mem_ready = stall_force ? 1'b0 : ((rc % 5) != 3);
    if (mem_valid && mem_ready) begin
      logic [127:0] eb;
      for (int i = 0; i < 16; i++) eb[i*8 +: 8] = pat(exp_src + 32'(sink_k * 16 + i));
      if (eb !== mem_data || mem_addr !== exp_dst + 32'(sink_k * 16)) sink_err++;
      sink_k++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int n = 0; n < 20000; n++) begin
      rd(4'd0, v);
      if (v[0] == 1'b0) begin ok = 1; break; end
    end
  endtask

  // expected frame parameters derived from R3..R6
  task automatic set_expect(input vec_t v, output logic [7:0] op);
    bit q, d;
    q = v.bus[2];
    d = v.bus[0] && !q;
    op = q ? 8'h6B : d ? 8'h3B : v.fast ? 8'h0B : 8'h03;
    fm_dl = q ? 4 : d ? 2 : 1;
    fm_al = (q && v.bus[3]) ? 4 : (d && v.bus[1]) ? 2 : 1;
    fm_dum = (q || d || v.fast) ? 8 : 0;
    fm_wide = v.bus[4];
    exp_src = v.bus[4] ? v.src : {8'h00, v.src[23:0]};
    exp_dst = v.dst;
    sink_k = 0; sink_err = 0;
  endtask

  task automatic run_vec(input vec_t v, input int id);
    logic [7:0] op;
    logic [31:0] r;
    bit ok;
    set_expect(v, op);
    wr(4'd1, v.src); wr(4'd2, v.dst); wr(4'd3, v.dst + 32'(v.nb) * 16);
    wr(4'd4, {27'h0, v.bus}); wr(4'd5, {31'h0, v.fast});
    wr(4'd0, 32'h1);
    rd(4'd0, r);
    check(r[0] == 1'b1, $sformatf("R2 run bit set vec%0d", id), r[0], 1);
    wait_idle(ok);
    check(ok, $sformatf("R2 run bit clears vec%0d", id), ok, 1);
    check(fm_op == op, $sformatf("R3 opcode vec%0d", id), fm_op, op);
    check(fm_addr == exp_src, $sformatf("R4 address vec%0d", id), fm_addr, exp_src);
    check(fm_cnt == hdr_len() + 32'(v.nb) * 16 * 8 / fm_dl,
          $sformatf("R5 R6 frame clocks vec%0d", id), fm_cnt, hdr_len() + 32'(v.nb) * 128 / fm_dl);
    check(sink_k == int'(v.nb) && sink_err == 0, $sformatf("R7 words vec%0d", id), sink_err, 0);
    rd(4'd8, r);
    check(r[7] && irq && flash_cs_n && !flash_sclk, $sformatf("R2 R11 completion vec%0d", id), r, 32'h80);
    wr(4'd8, 32'h80);
    rd(4'd8, r);
    check(r[7] == 1'b0 && !irq, $sformatf("R2 status clear vec%0d", id), r, 0);
  endtask

  initial begin
    logic [31:0] r;
    bit ok, held;
    int falls0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(4'd0, r);
    check(r == 0 && !irq && flash_cs_n && !flash_sclk && !mem_valid, "R1 reset state", r, 0);
    rd(4'd8, r);
    check(r == 0, "R1 status after reset", r, 0);
    wr(4'd6, 32'h3B); wr(4'd7, 32'h6B);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R8 long backpressure: four-lane read with the sink stalled
    begin
      vec_t v;
      logic [7:0] op;
      v = '{5'h0C, 1'b0, 32'h00005000, 32'h50000000, 8'd2};
      set_expect(v, op);
      wr(4'd1, v.src); wr(4'd2, v.dst); wr(4'd3, v.dst + 32);
      wr(4'd4, {27'h0, v.bus}); wr(4'd5, 0);
      stall_force = 1;
      wr(4'd0, 32'h1);
      for (int n = 0; n < 2000 && !mem_valid; n++) @(negedge clk);
      repeat (4) @(negedge clk);
      held = 1;
      for (int n = 0; n < 100; n++) begin
        @(negedge clk);
        if (flash_sclk || flash_cs_n || !mem_valid) held = 0;
      end
      check(held, "R8 serial clock held low during stall", held, 1);
      stall_force = 0;
      wait_idle(ok);
      check(ok && sink_k == 2 && sink_err == 0, "R8 no byte lost after stall", sink_err, 0);
      wr(4'd8, 32'h80);
    end

    // R9 writes ignored while running
    begin
      vec_t v;
      logic [7:0] op;
      v = '{5'h00, 1'b0, 32'h00000400, 32'h60000000, 8'd2};
      set_expect(v, op);
      wr(4'd1, v.src); wr(4'd2, v.dst); wr(4'd3, v.dst + 32);
      wr(4'd4, 0); wr(4'd5, 0);
      falls0 = cs_falls;
      wr(4'd0, 32'h1);
      wr(4'd1, 32'hDEAD0000); wr(4'd4, 32'h1F); wr(4'd3, 32'h60001000); wr(4'd0, 32'h1);
      wait_idle(ok);
      rd(4'd1, r);
      check(r == v.src, "R9 source unchanged", r, v.src);
      rd(4'd4, r);
      check(r == 0, "R9 lane setup unchanged", r, 0);
      check(sink_k == 2 && sink_err == 0 && cs_falls == falls0 + 1, "R9 restart ignored", sink_k, 2);
      wr(4'd8, 32'h80);
    end

    // R10 zero length
    falls0 = cs_falls;
    wr(4'd2, 32'h70000000); wr(4'd3, 32'h70000000);
    wr(4'd0, 32'h1);
    rd(4'd0, r);
    check(r[0] == 1'b0, "R10 run bit stays clear", r, 0);
    rd(4'd8, r);
    check(r[7] == 1'b1 && irq, "R10 completion flagged", r, 32'h80);
    repeat (20) @(negedge clk);
    check(cs_falls == falls0 && flash_cs_n && !mem_valid, "R10 no frame", cs_falls, falls0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule